// File: doc/BRIEF.md
# Microstep Phase Current Sequencer

This block turns a step clock into winding current targets for a two-phase bipolar stepper motor. It keeps an electrical position of 64 fine positions per cycle. On each rising edge of the step clock it moves the position one step forward or back. For every position it produces a current magnitude code, in percent, and a polarity bit for each of the two windings. A chopping current regulator downstream uses these values as its references.

Four step resolutions share one quarter-wave level table. The finest mode walks the table one entry at a time, and the coarser modes skip through it with larger strides. A home input, active low, holds the position at the initial point: winding A at full positive current and winding B at zero. An open-drain style flag marks that point. When home is released while the step clock is already high, the first step is taken at once.

A change of the resolution pins also forces the position back to the initial point. The torque select scales both references to a quarter of their level or leaves them at full level. The drive enable and the standby input turn the bridges off. With drive enable low the position keeps following the clock. With standby low, step edges are ignored.

All inputs are synchronous to `clk`. The position register updates on the `clk` edge that first sees a step event. The outputs follow that register, and the gating inputs, combinationally.

Top module: `ustep_sequencer`

## Requirements
- R1: `res_sel` (bit 0 is the first mode pin, bit 1 the second) sets the position stride per step: 2'b00 = 1 (16 steps per quarter wave, and the value the pins default to), 2'b01 = 8 (2 per quarter), 2'b10 = 4 (4 per quarter), 2'b11 = 2 (8 per quarter).
- R2: With `dir_ccw` = 0 a step adds the stride to the position, and with `dir_ccw` = 1 it subtracts it. Both wrap modulo 64. Without a step event the position holds.
- R3: The quarter table levels for index 0 to 16 are 100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10,0. Let r = position mod 32. The winding A level is Q[r] for r up to 16 and Q[32-r] otherwise. The winding B level is the winding A level of position (p+48) mod 64.
- R4: A polarity bit (`a_rev`, `b_rev`) is 1 when the current runs from output 2 to output 1. Winding A is reversed at positions 17 to 47, and winding B when (p+48) mod 64 lies in 17 to 47. A polarity bit is never 1 while its level is 0.
- R5: While `home_n` is low, the position is cleared to 0 at each `clk` edge, with A at +100 and B at 0.
- R6: At release of `home_n`, if `step_clk` is already high, a step is taken at the first `clk` edge that sees `home_n` high. Otherwise no step is taken until the next rising edge of `step_clk`.
- R7: A change of `res_sel` clears the position to 0 at the `clk` edge that sees it, and any step in that cycle is dropped. Later steps use the new stride.
- R8: With `drive_en` low, `bridge_on`, both references and both polarity bits are 0, and steps still move the position. When `drive_en` returns high, the outputs show the advanced position.
- R9: With `standby_n` low, the outputs are off as in R8 and step edges are ignored, so the position holds.
- R10: With `torque_full` = 0 each reference is floor(level/4), and with `torque_full` = 1 it equals the level.
- R11: `home_pull` is 1 exactly while the position is 0, whatever the state of `drive_en` and `standby_n`.
- R12: Each rising edge of `step_clk` gives one step, and a `step_clk` held high gives no further steps.
- R13: After `rst_n` is released, the position is 0 and a `step_clk` that is already high gives no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_clk | input | 1 | Step clock; each rising edge gives one step |
| dir_ccw | input | 1 | 0 steps forward, 1 steps backward |
| res_sel | input | 2 | Step resolution select |
| home_n | input | 1 | Active low; holds the position at the initial point |
| drive_en | input | 1 | Bridge enable; the position keeps running while low |
| standby_n | input | 1 | Active low; bridges off and steps ignored |
| torque_full | input | 1 | 1 gives full reference, 0 gives quarter reference |
| a_ref | output | 7 | Winding A current reference in percent |
| a_rev | output | 1 | Winding A reversed polarity |
| b_ref | output | 7 | Winding B current reference in percent |
| b_rev | output | 1 | Winding B reversed polarity |
| bridge_on | output | 1 | Bridges driving |
| home_pull | output | 1 | 1 while at the initial position (pulls the flag pin low) |

## Verification
A wrong position shows up at both references and both polarity bits in the cycle after the offending `clk` edge. The error then persists until the next home or mode clear, because every later step adds to it. A wrong stride or direction therefore shows as a level pair that does not match the expected table point after the very first step in that mode. Errors in the edge logic, such as a missed release step, a repeated step on a held level, or a step leaking through standby, show as a one-stride offset at the next sample. Faults in gating and torque scaling show at once at the references, independent of the position.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

  localparam int POS_W  = 6;
  localparam int IDX_W  = POS_W - 2;
  localparam int QSTEPS = 1 << IDX_W;
  localparam int LVL_W  = 7;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    RES_SIXTEENTH = 2'b00,
    RES_HALF      = 2'b01,
    RES_QUARTER   = 2'b10,
    RES_EIGHTH    = 2'b11
  } res_e;

  // Stride of the fine position for one step of the selected resolution.
  function automatic logic [POS_W-1:0] stride(input logic [SEL_W-1:0] sel);
    case (res_e'(sel))
      RES_SIXTEENTH: return POS_W'(1);
      RES_HALF:      return POS_W'(8);
      RES_QUARTER:   return POS_W'(4);
      RES_EIGHTH:    return POS_W'(2);
      default:       return POS_W'(1);
    endcase
  endfunction

  // Level in percent at index k of the quarter wave, k = 0..QSTEPS.
  function automatic logic [LVL_W-1:0] quarter_level(input logic [IDX_W:0] k);
    case (k)
      5'd0:    return LVL_W'(100);
      5'd1:    return LVL_W'(100);
      5'd2:    return LVL_W'(98);
      5'd3:    return LVL_W'(96);
      5'd4:    return LVL_W'(92);
      5'd5:    return LVL_W'(88);
      5'd6:    return LVL_W'(83);
      5'd7:    return LVL_W'(77);
      5'd8:    return LVL_W'(71);
      5'd9:    return LVL_W'(63);
      5'd10:   return LVL_W'(56);
      5'd11:   return LVL_W'(47);
      5'd12:   return LVL_W'(38);
      5'd13:   return LVL_W'(29);
      5'd14:   return LVL_W'(20);
      5'd15:   return LVL_W'(10);
      default: return LVL_W'(0);
    endcase
  endfunction

  // Torque scaling: full level or floor of a quarter.
  function automatic logic [LVL_W-1:0] scale_ref(input logic [LVL_W-1:0] lvl,
                                                 input logic full);
    return full ? lvl : (lvl >> 2);
  endfunction

endpackage

// File: rtl/ustep_step_detect.sv
module ustep_step_detect #(
  parameter int SEL_W = ustep_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_clk,
  input  logic             home_n,
  input  logic             standby_n,
  input  logic [SEL_W-1:0] res_sel,
  output logic             step_req,
  output logic             clear_req,
  output logic [SEL_W-1:0] res_q
);

  logic step_clk_q;
  logic home_q;
  logic clk_rise;
  logic release_high;
  logic mode_change;

  // Held-high history after reset so a level present at reset gives no step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_clk_q <= 1'b1;
      home_q     <= 1'b1;
      res_q      <= '0;
    end else begin
      step_clk_q <= step_clk;
      home_q     <= home_n;
      res_q      <= res_sel;
    end
  end

  assign clk_rise     = step_clk & ~step_clk_q;
  assign release_high = step_clk & home_n & ~home_q;
  assign mode_change  = (res_sel != res_q);
  assign clear_req    = ~home_n | mode_change;
  assign step_req     = standby_n & home_n & ~mode_change & (clk_rise | release_high);

  assert_hold_no_restep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (step_clk && $past(step_clk) && home_n && $past(home_n)) |-> !step_req);

  assert_standby_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |-> !step_req);

  assert_clear_beats_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |-> !step_req);

endmodule

// File: rtl/ustep_position.sv
module ustep_position #(
  parameter int POS_W = ustep_pkg::POS_W,
  parameter int SEL_W = ustep_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_req,
  input  logic             clear_req,
  input  logic             dir_ccw,
  input  logic [SEL_W-1:0] res_q,
  output logic [POS_W-1:0] pos
);

  logic [POS_W-1:0] step_amt;

  assign step_amt = ustep_pkg::stride(res_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos <= '0;
    else if (clear_req)  pos <= '0;
    else if (step_req)   pos <= dir_ccw ? (pos - step_amt) : (pos + step_amt);
  end

  assert_clear_to_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (pos == '0));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_req && !clear_req) |=> $stable(pos));

  assert_step_by_stride_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !clear_req) |=>
      (((pos - $past(pos)) == $past(step_amt)) || (($past(pos) - pos) == $past(step_amt))));

endmodule

// File: rtl/ustep_phase_map.sv
module ustep_phase_map #(
  parameter int POS_W  = ustep_pkg::POS_W,
  parameter int LVL_W  = ustep_pkg::LVL_W,
  parameter int OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  output logic [LVL_W-1:0] mag,
  output logic             neg
);

  localparam int IDX_W  = POS_W - 2;
  localparam int QSTEPS = 1 << IDX_W;

  logic [POS_W-1:0] p;
  logic [1:0]       quad;
  logic [IDX_W:0]   k;
  logic [IDX_W:0]   sel;

  assign p    = pos - POS_W'(OFFSET);
  assign quad = p[POS_W-1 -: 2];
  assign k    = {1'b0, p[IDX_W-1:0]};
  // Odd quadrants read the table backwards.
  assign sel  = quad[0] ? ((IDX_W+1)'(QSTEPS) - k) : k;
  assign mag  = ustep_pkg::quarter_level(sel);
  assign neg  = ((quad == 2'b01) || (quad == 2'b10)) && (mag != '0);

  assert_zero_at_odd_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p[IDX_W-1:0] == '0 && quad[0]) |-> (mag == '0 && !neg));

endmodule

// File: rtl/ustep_out_gate.sv
module ustep_out_gate #(
  parameter int LVL_W  = ustep_pkg::LVL_W,
  parameter int PHASES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PHASES-1:0][LVL_W-1:0] mag,
  input  logic [PHASES-1:0]            neg,
  input  logic                         drive_en,
  input  logic                         standby_n,
  input  logic                         torque_full,
  output logic [PHASES-1:0][LVL_W-1:0] ref_out,
  output logic [PHASES-1:0]            rev_out,
  output logic                         bridge_on
);

  assign bridge_on = drive_en & standby_n;

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign ref_out[i] = bridge_on ? ustep_pkg::scale_ref(mag[i], torque_full) : '0;
    assign rev_out[i] = bridge_on & neg[i];

    assert_quarter_torque_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_on && !torque_full) |-> (ref_out[i] <= LVL_W'(25)));
  end

endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer #(
  parameter int POS_W = ustep_pkg::POS_W,
  parameter int LVL_W = ustep_pkg::LVL_W,
  parameter int SEL_W = ustep_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_clk,
  input  logic             dir_ccw,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             home_n,
  input  logic             drive_en,
  input  logic             standby_n,
  input  logic             torque_full,
  output logic [LVL_W-1:0] a_ref,
  output logic             a_rev,
  output logic [LVL_W-1:0] b_ref,
  output logic             b_rev,
  output logic             bridge_on,
  output logic             home_pull
);

  localparam int PHASES = 2;
  localparam int QUARTER = 1 << (POS_W - 2);

  logic                         step_req;
  logic                         clear_req;
  logic [SEL_W-1:0]             res_q;
  logic [POS_W-1:0]             pos;
  logic [PHASES-1:0][LVL_W-1:0] mag;
  logic [PHASES-1:0]            neg;
  logic [PHASES-1:0][LVL_W-1:0] ref_out;
  logic [PHASES-1:0]            rev_out;

  ustep_step_detect #(.SEL_W(SEL_W)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_clk  (step_clk),
    .home_n    (home_n),
    .standby_n (standby_n),
    .res_sel   (res_sel),
    .step_req  (step_req),
    .clear_req (clear_req),
    .res_q     (res_q)
  );

  ustep_position #(.POS_W(POS_W), .SEL_W(SEL_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (step_req),
    .clear_req (clear_req),
    .dir_ccw   (dir_ccw),
    .res_q     (res_q),
    .pos       (pos)
  );

  // Winding B lags winding A by one quarter wave.
  for (genvar ph = 0; ph < PHASES; ph++) begin : g_map
    ustep_phase_map #(.POS_W(POS_W), .LVL_W(LVL_W), .OFFSET(ph * QUARTER)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .mag   (mag[ph]),
      .neg   (neg[ph])
    );
  end

  ustep_out_gate #(.LVL_W(LVL_W), .PHASES(PHASES)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .mag         (mag),
    .neg         (neg),
    .drive_en    (drive_en),
    .standby_n   (standby_n),
    .torque_full (torque_full),
    .ref_out     (ref_out),
    .rev_out     (rev_out),
    .bridge_on   (bridge_on)
  );

  assign a_ref     = ref_out[0];
  assign b_ref     = ref_out[1];
  assign a_rev     = rev_out[0];
  assign b_rev     = rev_out[1];
  assign home_pull = (pos == '0);

  assert_home_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
    home_pull |-> (mag[0] == LVL_W'(100) && mag[1] == '0 && !neg[0] && !neg[1]));

  assert_home_low_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !home_n |=> home_pull);

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (a_ref == '0 && b_ref == '0 && !a_rev && !b_rev && !bridge_on));

  assert_polarity_needs_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rev |-> a_ref != '0 || !torque_full) and (b_rev |-> b_ref != '0 || !torque_full));

endmodule

// File: tb/ustep_sequencer_tb.sv
module ustep_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_clk = 1'b0;
  logic       dir_ccw = 1'b0;
  logic [1:0] res_sel = 2'b00;
  logic       home_n = 1'b1;
  logic       drive_en = 1'b1;
  logic       standby_n = 1'b1;
  logic       torque_full = 1'b1;
  logic [6:0] a_ref, b_ref;
  logic       a_rev, b_rev, bridge_on, home_pull;

  int checks = 0;
  int fails  = 0;
  int mpos   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ustep_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .dir_ccw(dir_ccw),
    .res_sel(res_sel), .home_n(home_n), .drive_en(drive_en),
    .standby_n(standby_n), .torque_full(torque_full),
    .a_ref(a_ref), .a_rev(a_rev), .b_ref(b_ref), .b_rev(b_rev),
    .bridge_on(bridge_on), .home_pull(home_pull)
  );

  localparam int QT [17] = '{100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10,0};

  // {res_sel, dir_ccw, step count, expected final position}
  localparam logic [16:0] VEC [8] = '{
    {2'b00, 1'b0, 8'd5,  6'd5},
    {2'b01, 1'b0, 8'd3,  6'd24},
    {2'b10, 1'b1, 8'd3,  6'd52},
    {2'b11, 1'b0, 8'd40, 6'd16},
    {2'b00, 1'b1, 8'd1,  6'd63},
    {2'b01, 1'b1, 8'd9,  6'd56},
    {2'b11, 1'b1, 8'd17, 6'd30},
    {2'b10, 1'b0, 8'd20, 6'd16}
  };

  function automatic int lvl_a(int p);
    int r = p % 32;
    return (r <= 16) ? QT[r] : QT[32 - r];
  endfunction

  function automatic bit rev_a(int p);
    return (p > 16) && (p < 48);
  endfunction

  function automatic int stride_of(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 8;
      2'b10: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit on = drive_en && standby_n;
    int pb = (mpos + 48) % 64;
    int la = lvl_a(mpos);
    int lb = lvl_a(pb);
    int ea = on ? (torque_full ? la : la / 4) : 0;
    int eb = on ? (torque_full ? lb : lb / 4) : 0;
    cmp(req, "a_ref", int'(a_ref), ea);
    cmp(req, "b_ref", int'(b_ref), eb);
    cmp(req, "a_rev", int'(a_rev), int'(on && rev_a(mpos)));
    cmp(req, "b_rev", int'(b_rev), int'(on && rev_a(pb)));
    cmp(req, "bridge_on", int'(bridge_on), int'(on));
    cmp(req, "home_pull", int'(home_pull), int'(mpos == 0));
  endtask

  task automatic pulse_step();
    @(negedge clk) step_clk = 1'b1;
    @(negedge clk) step_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_home();
    @(negedge clk) home_n = 1'b0;
    @(negedge clk) home_n = 1'b1;
    @(negedge clk);
    mpos = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      finish_run();
    end
  end

  initial begin
    // R13: step_clk already high through reset release
    step_clk = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mpos = 0;
    check_all("R13 reset state");
    step_clk = 1'b0;
    @(negedge clk);

    // Vector table: R1 R2 R3 R4 across every resolution and direction
    for (int v = 0; v < 8; v++) begin
      logic [1:0] m = VEC[v][16:15];
      logic       d = VEC[v][14];
      int         n = int'(VEC[v][13:6]);
      int         e = int'(VEC[v][5:0]);
      @(negedge clk) begin res_sel = m; dir_ccw = d; end
      go_home();
      check_all("R5 home before vector");
      for (int s = 0; s < n; s++) begin
        pulse_step();
        mpos = d ? (mpos - stride_of(m) + 64) % 64 : (mpos + stride_of(m)) % 64;
        check_all("R1 R2 R3 R4 step");
      end
      cmp("R1 R2 final", "position", mpos, e);
    end

    // R12: held level gives one step only
    @(negedge clk) begin res_sel = 2'b00; dir_ccw = 1'b0; end
    go_home();
    @(negedge clk) step_clk = 1'b1;
    repeat (4) @(negedge clk);
    mpos = 1;
    check_all("R12 held high");
    step_clk = 1'b0;
    @(negedge clk);

    // R6: release while step_clk high steps at once
    @(negedge clk) begin home_n = 1'b0; step_clk = 1'b1; end
    @(negedge clk);
    mpos = 0;
    check_all("R5 held home");
    home_n = 1'b1;
    @(negedge clk);
    mpos = 1;
    check_all("R6 release high");
    repeat (2) @(negedge clk);
    check_all("R6 no second step");
    step_clk = 1'b0;
    // R6: release with step_clk low waits for a rising edge
    go_home();
    repeat (3) @(negedge clk);
    check_all("R6 release low waits");
    pulse_step();
    mpos = 1;
    check_all("R6 step after release");

    // R7: mode change clears, new stride follows
    repeat (4) pulse_step();
    mpos = 5;
    check_all("R7 before change");
    @(negedge clk) res_sel = 2'b01;
    @(negedge clk);
    mpos = 0;
    check_all("R7 change clears");
    pulse_step();
    mpos = 8;
    check_all("R7 new stride");

    // R8: disabled outputs, counter keeps running
    @(negedge clk) begin res_sel = 2'b00; drive_en = 1'b0; end
    @(negedge clk);
    mpos = 0;
    check_all("R8 R11 disabled at home");
    repeat (3) pulse_step();
    mpos = 3;
    check_all("R8 disabled stepping");
    @(negedge clk) drive_en = 1'b1;
    @(negedge clk);
    check_all("R8 re-enabled");

    // R9: standby ignores steps
    @(negedge clk) standby_n = 1'b0;
    repeat (2) pulse_step();
    check_all("R9 standby");
    @(negedge clk) standby_n = 1'b1;
    @(negedge clk);
    check_all("R9 after standby");

    // R10: quarter torque at position 1 (100/10 -> 25/2)
    go_home();
    pulse_step();
    mpos = 1;
    @(negedge clk) torque_full = 1'b0;
    @(negedge clk);
    check_all("R10 quarter torque");
    cmp("R10", "b_ref quarter", int'(b_ref), 2);
    @(negedge clk) torque_full = 1'b1;
    @(negedge clk);
    check_all("R10 full torque");

    // R4: zero level at position 16 carries no reversed polarity
    repeat (15) pulse_step();
    mpos = 16;
    check_all("R4 zero crossing");
    cmp("R4", "a_rev at zero", int'(a_rev), 0);

    done = 1;
    finish_run();
  end

endmodule